// File: doc/BRIEF.md
# GPIO Pad Controller with Event Interrupts

This block controls a bank of general-purpose pads (up to 32) through a simple 32-bit register bus. Every pad owns a pair of configuration words. They hold the output value, separate enables for the driver and receiver, a function selector, and an input inversion. They also hold a three-way event mode and a pull selection. Pad inputs pass through a two-flop synchroniser. The receive value is then formed, optionally inverted, and fed to a per-pad event detector that works in level or rising-edge mode. The event mode can also hold the internal receive value at zero.

Detected events set sticky status bits. Software clears a status bit by writing a one to it. A status bit reaches the single interrupt line only when its pad's enable bit and its host-software-owner bit are both set. The block also keeps pad-ownership words as plain read/write storage.

The bus is plain control: a request with write strobe, address and write data. A read returns its data with a one-cycle valid pulse on the clock after the request. The bus is always ready, so there is no back-pressure.

Top module: `gpio_padctl`

## Requirements
- R1: After reset the status, enable, host-owner and ownership registers read 0, `irq` and every `pad_oe` bit are 0, and each pad's first word reads 0x0000_0100 (transmit disabled) while its input is low.
- R2: Pad n's first word is at PAD_BASE + 8n and its second word at PAD_BASE + 8n + 4. In the first word, bit 0 is the transmit value, bit 8 disables transmit, bit 9 disables receive, bits 13:10 are the function, bit 23 inverts, bits 26:25 are the event mode and bit 28 forces receive to one. All other bits read 0. A read request returns data with `rsp_valid` high on the next clock.
- R3: `pad_oe[n]` is high only when transmit is not disabled and the function field is 0. `pad_out[n]` always carries the stored transmit bit.
- R4: Bit 1 of the first word is the receive value: 0 if receive is disabled, otherwise 1 if the force bit is set, otherwise the input after a two-flop synchroniser. Bit 0 reads the transmit bit when transmit is enabled and the receive value when it is disabled.
- R5: Event mode 0 sets the status bit on every clock that the (possibly inverted) receive value is high. Mode 1 sets it only on a 0-to-1 change. Modes 2 and 3 hold the internal value at zero, so no event occurs. A non-zero function field also suppresses events.
- R6: With bit 23 set, a low receive value counts as active for event detection.
- R7: The status register is at 0x100, one bit per pad. Writing 1 clears a bit and writing 0 leaves it. If a set and a clear fall in the same clock, the bit stays set.
- R8: The enable register is at 0x110 and the host-owner register at 0x80. `irq` is registered and goes high one clock after any pad has status, enable and host-owner all set.
- R9: Bits 13:10 of the second word select the pull: 12 drives `pull_up`, 4 drives `pull_dn`, and any other value drives neither. The field reads back as written and all other bits read 0.
- R10: The ownership words start at 0x20 and hold 2 bits per pad, 16 pads per word. They read back as written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Pad output values |
| pad_oe | output | NUM_PADS | Pad output enables (0 = tri-state) |
| pull_up | output | NUM_PADS | Pull-up select per pad |
| pull_dn | output | NUM_PADS | Pull-down select per pad |
| irq | output | 1 | Combined interrupt |

## Verification
The event detector setting a status bit and a software write-1-to-clear can land on the same clock. The bench provokes this by holding a level-mode input active and writing a one to its status bit. It judges the result by a read-back that still shows the bit set. It then releases the input and repeats the clear, which must now take effect. A rising-edge pad is cleared while its input stays high, and the bit must stay clear because no new edge has occurred.

// File: rtl/gpio_padctl_pkg.sv
package gpio_padctl_pkg;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_RISE  = 2'd1,
    EV_HOLD0 = 2'd2,
    EV_RSVD  = 2'd3
  } ev_mode_e;

  typedef struct packed {
    logic       force1;
    ev_mode_e   mode;
    logic       inv;
    logic [3:0] func;
    logic       rx_off;
    logic       tx_off;
    logic       tx;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_RST = '{force1: 1'b0, mode: EV_LEVEL, inv: 1'b0,
                                   func: 4'd0, rx_off: 1'b0, tx_off: 1'b1, tx: 1'b0};

  localparam logic [3:0] PULL_DN_CODE = 4'd4;
  localparam logic [3:0] PULL_UP_CODE = 4'd12;

  function automatic pad_cfg_t cfg_from_word(input logic [31:0] w);
    pad_cfg_t c;
    c.tx     = w[0];
    c.tx_off = w[8];
    c.rx_off = w[9];
    c.func   = w[13:10];
    c.inv    = w[23];
    c.mode   = ev_mode_e'(w[26:25]);
    c.force1 = w[28];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input pad_cfg_t c, input logic rxv);
    return {3'b0, c.force1, 1'b0, c.mode, 1'b0, c.inv, 9'b0, c.func,
            c.rx_off, c.tx_off, 6'b0, rxv, (c.tx_off ? rxv : c.tx)};
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pad_event.sv
module gpio_pad_event
  import gpio_padctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rxv,
  input  pad_cfg_t cfg,
  input  logic     clr,
  output logic     sts
);
  logic ev_in, ev_prev, set_evt;

  always_comb begin
    ev_in = 1'b0;
    if ((cfg.mode == EV_LEVEL || cfg.mode == EV_RISE) && cfg.func == 4'd0)
      ev_in = rxv ^ cfg.inv;
    case (cfg.mode)
      EV_LEVEL: set_evt = ev_in;
      EV_RISE:  set_evt = ev_in & ~ev_prev;
      default:  set_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_prev <= 1'b0;
      sts     <= 1'b0;
    end else begin
      ev_prev <= ev_in;
      sts     <= (sts & ~clr) | set_evt;
    end
  end

  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !sts);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> sts);
  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode inside {EV_HOLD0, EV_RSVD} && !sts) |=> !sts);
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl
  import gpio_padctl_pkg::*;
#(
  parameter int          NUM_PADS = 32,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] PAD_BASE = 12'h400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pull_up,
  output logic [NUM_PADS-1:0] pull_dn,
  output logic                irq
);
  localparam int OWN_WORDS = (2 * NUM_PADS + 31) / 32;
  localparam logic [ADDR_W-1:0] A_OWN = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] A_HSW = ADDR_W'(12'h080);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(12'h110);

  logic wr, rd;
  assign wr = bus_req & bus_we;
  assign rd = bus_req & ~bus_we;

  pad_cfg_t            cfg  [NUM_PADS];
  logic [3:0]          pull [NUM_PADS];
  logic [31:0]         own  [OWN_WORDS];
  logic [NUM_PADS-1:0] hsw, en, sts, clr, sync_in, rxv;

  gpio_pad_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sync_in)
  );

  assign clr = (wr && bus_addr == A_STS) ? bus_wdata[NUM_PADS-1:0] : '0;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(PAD_BASE + 12'(8 * p));
    localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(PAD_BASE + 12'(8 * p + 4));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[p]  <= CFG_RST;
        pull[p] <= 4'd0;
      end else if (wr) begin
        if (bus_addr == A_CFG0) cfg[p]  <= cfg_from_word(bus_wdata);
        if (bus_addr == A_CFG1) pull[p] <= bus_wdata[13:10];
      end
    end

    assign rxv[p]     = cfg[p].rx_off ? 1'b0 : (cfg[p].force1 | sync_in[p]);
    assign pad_out[p] = cfg[p].tx;
    assign pad_oe[p]  = ~cfg[p].tx_off & (cfg[p].func == 4'd0);
    assign pull_up[p] = (pull[p] == PULL_UP_CODE);
    assign pull_dn[p] = (pull[p] == PULL_DN_CODE);

    gpio_pad_event u_event (
      .clk(clk), .rst_n(rst_n), .rxv(rxv[p]), .cfg(cfg[p]),
      .clr(clr[p]), .sts(sts[p])
    );
  end

  for (genvar w = 0; w < OWN_WORDS; w++) begin : g_own
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          own[w] <= '0;
      else if (wr && bus_addr == A_OWN + ADDR_W'(4 * w))   own[w] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsw <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      if (wr && bus_addr == A_HSW) hsw <= bus_wdata[NUM_PADS-1:0];
      if (wr && bus_addr == A_EN)  en  <= bus_wdata[NUM_PADS-1:0];
      irq <= |(sts & en & hsw);
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_HSW) rd_mux = 32'(hsw);
    if (bus_addr == A_EN)  rd_mux = 32'(en);
    if (bus_addr == A_STS) rd_mux = 32'(sts);
    for (int w = 0; w < OWN_WORDS; w++)
      if (bus_addr == A_OWN + ADDR_W'(4 * w)) rd_mux = own[w];
    for (int p = 0; p < NUM_PADS; p++) begin
      if (bus_addr == ADDR_W'(PAD_BASE + 12'(8 * p)))
        rd_mux = cfg_to_word(cfg[p], rxv[p]);
      if (bus_addr == ADDR_W'(PAD_BASE + 12'(8 * p + 4)))
        rd_mux = {18'b0, pull[p], 10'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  assert_rsp_only_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts & en & hsw)) |=> irq);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts & en & hsw)) |=> !irq);
endmodule

// File: tb/gpio_padctl_tb.sv
module gpio_padctl_tb;
  localparam int NP = 32;
  localparam logic [11:0] PB = 12'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pull_up, pull_dn;
  logic irq;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  gpio_padctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, input string req);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] c0(input int p); return PB + 12'(8 * p); endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pad_oe", pad_oe, 0);
    rd(c0(0), d, "R1"); chk("R1 cfg0", d, 32'h100);
    rd(12'h100, d, "R1"); chk("R1 status", d, 0);
    rd(12'h020, d, "R1"); chk("R1 owner", d, 0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(c0(5), 32'hFFFF_FFFF);
    rd(c0(5), d, "R2"); chk("R2 cfg0 fields", d, 32'h1680_3F00);
    wr(c0(5), 32'h100);
  endtask

  task automatic t_output();
    logic [31:0] d;
    wr(c0(2), 32'h1);
    chk("R3 oe", 32'(pad_oe[2]), 1); chk("R3 out", 32'(pad_out[2]), 1);
    rd(c0(2), d, "R4"); chk("R4 tx readback", d, 32'h1);
    wr(c0(2), 32'h401);
    chk("R3 func blocks oe", 32'(pad_oe[2]), 0);
  endtask

  task automatic t_receive();
    logic [31:0] d;
    pad_in[1] = 1'b1; settle(3);
    rd(c0(1), d, "R4"); chk("R4 rx input", d, 32'h103);
    pad_in[1] = 1'b0; settle(3);
    wr(c0(1), 32'h1000_0100);
    rd(c0(1), d, "R4"); chk("R4 force1", d, 32'h1000_0103);
    pad_in[1] = 1'b1; wr(c0(1), 32'h300); settle(3);
    rd(c0(1), d, "R4"); chk("R4 rx disabled", d, 32'h300);
  endtask

  task automatic t_level_clear();
    logic [31:0] d;
    wr(12'h110, 32'h10); wr(12'h080, 32'h10);
    pad_in[4] = 1'b1; settle(5);
    chk("R8 irq on level", 32'(irq), 1);
    wr(12'h100, 32'h0);
    rd(12'h100, d, "R7"); chk("R7 write0 keeps", d & 32'h10, 32'h10);
    wr(12'h100, 32'h10);
    rd(12'h100, d, "R7"); chk("R7 set wins over clear", d & 32'h10, 32'h10);
    pad_in[4] = 1'b0; settle(4);
    wr(12'h100, 32'h10);
    rd(12'h100, d, "R7"); chk("R7 clear after release", d & 32'h10, 0);
    chk("R8 irq drops", 32'(irq), 0);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    wr(12'h110, 32'h0);
    pad_in[4] = 1'b1; settle(5);
    chk("R8 irq gated by enable", 32'(irq), 0);
    wr(12'h080, 32'h0);
    wr(12'h110, 32'h10);
    chk("R8 irq gated by owner", 32'(irq), 0);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h080; bus_wdata = 32'h10;
    @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
    chk("R8 irq not yet", 32'(irq), 0);
    @(negedge clk);
    chk("R8 irq one clock later", 32'(irq), 1);
    rd(12'h080, d, "R8"); chk("R8 owner readback", d, 32'h10);
    pad_in[4] = 1'b0; settle(4); wr(12'h100, 32'h10); wr(12'h110, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(c0(6), 32'h0200_0100);
    pad_in[6] = 1'b1; settle(4);
    rd(12'h100, d, "R5"); chk("R5 rise sets", d & 32'h40, 32'h40);
    wr(12'h100, 32'h40); settle(3);
    rd(12'h100, d, "R5"); chk("R5 no reset while high", d & 32'h40, 0);
  endtask

  task automatic t_invert_hold();
    logic [31:0] d;
    wr(c0(7), 32'h0080_0100); settle(2);
    rd(12'h100, d, "R6"); chk("R6 inverted low input", d & 32'h80, 32'h80);
    wr(c0(8), 32'h0480_0100);
    for (int i = 0; i < 3; i++) begin
      pad_in[8] = ~pad_in[8]; settle(3);
    end
    rd(12'h100, d, "R5"); chk("R5 hold-zero mode", d & 32'h100, 0);
  endtask

  task automatic t_pull();
    logic [31:0] d;
    wr(c0(9) + 12'd4, 32'hFFFF_3000);
    chk("R9 pull up", {pull_up[9], pull_dn[9]}, 32'b10);
    rd(c0(9) + 12'd4, d, "R9"); chk("R9 readback", d, 32'h3000);
    wr(c0(9) + 12'd4, 32'h1000);
    chk("R9 pull down", {pull_up[9], pull_dn[9]}, 32'b01);
    wr(c0(9) + 12'd4, 32'h0800);
    chk("R9 no pull", {pull_up[9], pull_dn[9]}, 32'b00);
  endtask

  task automatic t_owner();
    logic [31:0] d;
    wr(12'h024, 32'hA5A5_5A5A);
    rd(12'h024, d, "R10"); chk("R10 owner word", d, 32'hA5A5_5A5A);
    rd(12'h200, d, "R10"); chk("R10 unmapped", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_fields();
    t_output();
    t_receive();
    t_level_clear();
    t_gating();
    t_edge();
    t_invert_hold();
    t_pull();
    t_owner();
    finish_run();
  end
endmodule